// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings a bank of asynchronous DRAM devices out of power-up and then keeps their contents alive. Straight out of reset it holds every strobe inactive for a long settling pause. It then runs a fixed burst of column-before-row refresh cycles back to back. Only after the last of those has finished its precharge does it flag the memory as ready. The devices keep their own internal row counter, so the block never drives an address.

Once the memory is ready, an interval timer raises a refresh request at the average spacing needed to visit every row within the retention period. The default is 2048 rows in 32.8 ms, about one every 16 µs. Requests that are not yet served accumulate in a capped counter. The access sequencer sees the request, closes its open page and returns a grant. The scheduler takes the bus only when it is idle, has work and sees the grant. It then drives one refresh cycle with a strict strobe order: column precharge, column strobes low, row strobe low, both high together, row precharge. Write enable stays high for the whole time. Every duration is turned into clock cycles from a clock-frequency parameter, rounding up.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is asserted, `rasN`, every bit of `casN` and `weN` are 1, `initDone` and `refReq` are 0, and `busOwn` is 1.
- R2: After reset is released, `rasN` and `casN` stay 1 for PAUSE_US×CLK_MHZ clock edges. The first refresh cycle begins on the next edge.
- R3: After the pause, exactly INIT_CYCLES refresh cycles run back to back without any grant. `initDone` rises on the edge that ends the last cycle's row precharge and then stays 1.
- R4: In each refresh cycle all `casN` bits go to 0 exactly ceil(T_CSR_NS) cycles before `rasN` goes to 0. They have been 1 for at least ceil(T_CPN_NS) cycles before that. They return to 1 on the same edge as `rasN`.
- R5: `rasN` stays 0 for max(ceil(T_RAS_NS), ceil(T_CHR_NS)) cycles. It is then followed by ceil(T_RP_NS) cycles with all strobes 1 before the bus is released or the next cycle starts.
- R6: `weN` is 1 at all times.
- R7: Once `initDone` is 1, a refresh is added to the pending count every floor(REFRESH_NS×CLK_MHZ/1000) cycles. `refReq` is 1 exactly when the pending count is non-zero.
- R8: After initialisation, a refresh cycle starts only on an edge where the block is idle, `refGrant` is 1 and the pending count is non-zero. That edge removes one from the count. While idle, all strobes are 1 and `busOwn` is 0.
- R9: The pending count never exceeds MAX_PEND. Interval ticks arriving at the cap are dropped.
- R10: `busOwn` is 1 from the edge a refresh starts until the edge that ends its row precharge.
- R11: Each duration in cycles is ceil(ns×CLK_MHZ/1000), with a minimum of 1. At 125 MHz with the defaults this gives 2, 1, 8 and 5 cycles for column precharge, column lead, row pulse and row precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Access sequencer has closed its page and yields the bus |
| refReq | output | 1 | At least one refresh is pending |
| busOwn | output | 1 | Scheduler drives the DRAM strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | NUM_CAS | Column strobes, active low, all driven together |
| weN | output | 1 | Write enable, active low, held high |
| initDone | output | 1 | Power-up sequence complete |

## Verification
The bench builds the block at 125 MHz with PAUSE_US=1, REFRESH_NS=800 and MAX_PEND=3. This shrinks the pause to 125 cycles and the refresh interval to 100 cycles. The whole power-up burst of eight cycles then finishes early in the run. Holding the grant low for a thousand cycles lets ten ticks arrive, so the cap of three is reached and exceeded many times over. Releasing the grant afterwards shows the stored refreshes draining back to back. The per-cycle model runs with the literal cycle counts 2/1/8/5, so a wrong rounding or ordering of any phase shows up as a strobe mismatch.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    PH_PAUSE = 3'd0,
    PH_IDLE  = 3'd1,
    PH_CPN   = 3'd2,
    PH_CSR   = 3'd3,
    PH_RAS   = 3'd4,
    PH_RP    = 3'd5
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadTimer;
    phase_e loadPh;
    logic   takeReq;
    logic   initStep;
  } ctlStrobe_t;

  function automatic int nsToCyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int PAUSE_US    = 200,
  parameter int REFRESH_NS  = 16015,
  parameter int T_CPN_NS    = 10,
  parameter int T_CSR_NS    = 5,
  parameter int T_RAS_NS    = 60,
  parameter int T_CHR_NS    = 10,
  parameter int T_RP_NS     = 40,
  parameter int INIT_CYCLES = 8,
  parameter int MAX_PEND    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       initDone,
  output logic       timerZero,
  output logic       pendAny,
  output logic       initLast
);

  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int CPN_CYC   = nsToCyc(T_CPN_NS, CLK_MHZ);
  localparam int CSR_CYC   = nsToCyc(T_CSR_NS, CLK_MHZ);
  localparam int RAS_CYC   = maxOf(nsToCyc(T_RAS_NS, CLK_MHZ), nsToCyc(T_CHR_NS, CLK_MHZ));
  localparam int RP_CYC    = nsToCyc(T_RP_NS, CLK_MHZ);
  localparam int IVL_CYC   = maxOf(REFRESH_NS * CLK_MHZ / 1000, 1);
  localparam int LONGEST   = maxOf(maxOf(PAUSE_CYC, RAS_CYC), maxOf(maxOf(CPN_CYC, CSR_CYC), RP_CYC));
  localparam int TW        = $clog2(LONGEST + 1);
  localparam int IW        = $clog2(IVL_CYC + 1);
  localparam int PW        = $clog2(MAX_PEND + 1);
  localparam int NW        = $clog2(INIT_CYCLES + 1);

  logic [TW-1:0] phaseTimer, loadVal;
  logic [IW-1:0] ivlCnt;
  logic [PW-1:0] pendCnt;
  logic [PW:0]   pendSum;
  logic [NW-1:0] initCnt;
  logic          tick;

  always_comb begin
    case (ctl.loadPh)
      PH_CPN:  loadVal = TW'(CPN_CYC - 1);
      PH_CSR:  loadVal = TW'(CSR_CYC - 1);
      PH_RAS:  loadVal = TW'(RAS_CYC - 1);
      PH_RP:   loadVal = TW'(RP_CYC - 1);
      default: loadVal = TW'(PAUSE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseTimer <= TW'(PAUSE_CYC - 1);
    else if (ctl.loadTimer)   phaseTimer <= loadVal;
    else if (phaseTimer != '0) phaseTimer <= phaseTimer - 1'b1;
  end
  assign timerZero = (phaseTimer == '0);

  assign tick = initDone && (ivlCnt == IW'(IVL_CYC - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ivlCnt <= '0;
    else if (tick)     ivlCnt <= '0;
    else if (initDone) ivlCnt <= ivlCnt + 1'b1;
  end

  always_comb begin
    pendSum = {1'b0, pendCnt} + {{PW{1'b0}}, tick} - {{PW{1'b0}}, ctl.takeReq};
    if (pendSum > (PW+1)'(MAX_PEND)) pendSum = (PW+1)'(MAX_PEND);
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else       pendCnt <= pendSum[PW-1:0];
  end
  assign pendAny = (pendCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             initCnt <= '0;
    else if (ctl.initStep) initCnt <= initCnt + 1'b1;
  end
  assign initLast = (initCnt == NW'(INIT_CYCLES - 1));

  // R9: pending count capped
  a_r9_pend_cap: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PW'(MAX_PEND));
  // R7: nothing accrues before initialisation ends
  a_r7_no_early_pend: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> pendCnt == '0);

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import dram_rfsh_pkg::*;
#(
  parameter int NUM_CAS = 8,
  parameter int RAS_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refGrant,
  input  logic               timerZero,
  input  logic               pendAny,
  input  logic               initLast,
  output ctlStrobe_t         ctl,
  output logic               initDone,
  output logic               busOwn,
  output logic               rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN
);

  localparam int RW = $clog2(RAS_CYC + 2);

  phase_e st, stNext;
  logic   doneNext;
  logic [RW-1:0] rasLowCnt;

  always_comb begin
    stNext   = st;
    doneNext = initDone;
    ctl      = '{loadTimer: 1'b0, loadPh: PH_IDLE, takeReq: 1'b0, initStep: 1'b0};
    case (st)
      PH_PAUSE: if (timerZero) begin stNext = PH_CPN; end
      PH_IDLE:  if (pendAny && refGrant) begin
                  stNext = PH_CPN;
                  ctl.takeReq = 1'b1;
                end
      PH_CPN:   if (timerZero) stNext = PH_CSR;
      PH_CSR:   if (timerZero) stNext = PH_RAS;
      PH_RAS:   if (timerZero) stNext = PH_RP;
      PH_RP:    if (timerZero) begin
                  stNext = PH_IDLE;
                  if (!initDone) begin
                    ctl.initStep = 1'b1;
                    if (initLast) doneNext = 1'b1;
                    else          stNext = PH_CPN;
                  end
                end
      default:  stNext = PH_IDLE;
    endcase
    if (stNext != st && stNext != PH_IDLE) begin
      ctl.loadTimer = 1'b1;
      ctl.loadPh    = stNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= PH_PAUSE;
      initDone <= 1'b0;
    end else begin
      st       <= stNext;
      initDone <= doneNext;
    end
  end

  assign rasN   = (st != PH_RAS);
  assign casN   = {NUM_CAS{!(st == PH_CSR || st == PH_RAS)}};
  assign weN    = 1'b1;
  assign busOwn = (st != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rasLowCnt <= '0;
    else if (rasN) rasLowCnt <= '0;
    else           rasLowCnt <= rasLowCnt + 1'b1;
  end

  // R4: column strobes lead the row strobe
  a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(casN) == '0);
  // R4: row low implies column low
  a_r4_cas_under_ras: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> casN == '0);
  // R5: full row pulse width
  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> rasLowCnt == RW'(RAS_CYC));
  // R8: post-init start only on grant
  a_r8_grant_start: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && $rose(busOwn)) |-> $past(refGrant));
  // R3: ready flag is sticky
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int PAUSE_US    = 200,
  parameter int REFRESH_NS  = 16015,
  parameter int T_CPN_NS    = 10,
  parameter int T_CSR_NS    = 5,
  parameter int T_RAS_NS    = 60,
  parameter int T_CHR_NS    = 10,
  parameter int T_RP_NS     = 40,
  parameter int INIT_CYCLES = 8,
  parameter int MAX_PEND    = 8,
  parameter int NUM_CAS     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refGrant,
  output logic               refReq,
  output logic               busOwn,
  output logic               rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN,
  output logic               initDone
);

  localparam int RAS_CYC = maxOf(nsToCyc(T_RAS_NS, CLK_MHZ), nsToCyc(T_CHR_NS, CLK_MHZ));

  ctlStrobe_t ctl;
  logic timerZero, pendAny, initLast;

  rfsh_datapath #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .REFRESH_NS(REFRESH_NS),
    .T_CPN_NS(T_CPN_NS), .T_CSR_NS(T_CSR_NS), .T_RAS_NS(T_RAS_NS),
    .T_CHR_NS(T_CHR_NS), .T_RP_NS(T_RP_NS),
    .INIT_CYCLES(INIT_CYCLES), .MAX_PEND(MAX_PEND)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .initDone(initDone),
    .timerZero(timerZero), .pendAny(pendAny), .initLast(initLast)
  );

  rfsh_control #(.NUM_CAS(NUM_CAS), .RAS_CYC(RAS_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .timerZero(timerZero), .pendAny(pendAny), .initLast(initLast),
    .ctl(ctl), .initDone(initDone), .busOwn(busOwn),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

  assign refReq = pendAny;

endmodule

// File: tb/sim_dram_rfsh_sched.sv
module sim_dram_rfsh_sched;

  localparam int P_CYC  = 125;
  localparam int IVL    = 100;
  localparam int MAXP   = 3;
  localparam int NINIT  = 8;
  localparam int CPN    = 2;
  localparam int CSR    = 1;
  localparam int RASL   = 8;
  localparam int RP     = 5;
  localparam int LEN    = CPN + CSR + RASL + RP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, busOwn, rasN, weN, initDone;
  logic [7:0] casN;

  always #4 clk = ~clk;

  dram_rfsh_sched #(
    .CLK_MHZ(125), .PAUSE_US(1), .REFRESH_NS(800), .MAX_PEND(MAXP),
    .INIT_CYCLES(NINIT), .NUM_CAS(8)
  ) u0 (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .busOwn(busOwn), .rasN(rasN), .casN(casN), .weN(weN), .initDone(initDone)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  mPause = 0, mPos = -1, mInits = 0, mPend = 0, mIvl = 0;
  bit  mInPause = 1, mDone = 0, mTick, mStart;

  always @(posedge clk) begin
    if (!rstN) begin
      mPause = 0; mPos = -1; mInits = 0; mPend = 0; mIvl = 0;
      mInPause = 1; mDone = 0;
    end else begin
      mTick = 0; mStart = 0;
      if (mDone) begin
        mIvl++;
        if (mIvl == IVL) begin mIvl = 0; mTick = 1; end
      end
      if (mDone && mPos < 0 && mPend > 0 && refGrant) mStart = 1;
      mPend = mPend + int'(mTick) - int'(mStart);
      if (mPend > MAXP) mPend = MAXP;
      if (mInPause) begin
        mPause++;
        if (mPause == P_CYC) begin mInPause = 0; mPos = 0; end
      end else if (mPos >= 0) begin
        mPos++;
        if (mPos == LEN) begin
          mPos = -1;
          if (!mDone) begin
            mInits++;
            if (mInits < NINIT) mPos = 0;
            else mDone = 1;
          end
        end
      end else if (mStart) mPos = 0;
    end
  end

  // observation state
  int  idx = 0, firstLow = -1, lowLen = 0, highLen = 0;
  int  initFalls = 0, winFalls = 0;
  bit  pRas = 1, pCas = 1, ppCas = 1;

  always @(negedge clk) begin
    bit eRas, eCas, eOwn;
    if (rstN) begin
      idx++;
      eRas = !(mPos >= CPN + CSR && mPos < LEN - RP);
      eCas = !(mPos >= CPN && mPos < LEN - RP);
      eOwn = !(mDone && mPos < 0);
      check(rasN == eRas, "R4 rasN", int'(rasN), int'(eRas));
      check(casN == {8{eCas}}, "R4 casN", int'(casN), eCas ? 255 : 0);
      check(weN == 1'b1, "R6 weN", int'(weN), 1);
      check(initDone == mDone, "R3 initDone", int'(initDone), int'(mDone));
      check(busOwn == eOwn, "R10 busOwn", int'(busOwn), int'(eOwn));
      check(refReq == (mPend > 0), "R7 refReq", int'(refReq), int'(mPend > 0));
      if (!mDone && mPos < 0 && mInPause == 0) ;
      if (!rasN && pRas) begin
        if (firstLow < 0) firstLow = idx;
        check(highLen >= CPN + CSR + RP, "R5 precharge gap", highLen, CPN + CSR + RP);
        check(pCas == 1'b0 && ppCas == 1'b1, "R4 cas lead", int'({ppCas, pCas}), 2);
        if (!initDone) initFalls++;
        winFalls++;
        highLen = 0;
      end
      if (rasN && !pRas) begin
        check(lowLen == RASL, "R5 R11 ras width", lowLen, RASL);
        check(casN == 8'hFF, "R4 cas rises with ras", int'(casN), 255);
        lowLen = 0;
      end
      if (!rasN) lowLen++; else highLen++;
      ppCas = pCas; pCas = casN[0]; pRas = rasN;
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rasN == 1 && weN == 1 && casN == 8'hFF, "R1 strobes high", int'({rasN, weN}), 3);
    check(initDone == 0 && refReq == 0, "R1 flags low", int'({initDone, refReq}), 0);
    check(busOwn == 1, "R1 busOwn", int'(busOwn), 1);
    #1 rstN = 1'b1;
    repeat (400) @(negedge clk);
    #1;
    check(firstLow == P_CYC + CPN + CSR, "R2 pause length", firstLow, P_CYC + CPN + CSR);
    check(initFalls == NINIT, "R3 init burst count", initFalls, NINIT);
    check(initDone == 1, "R3 done after burst", int'(initDone), 1);
    refGrant = 1'b1;
    repeat (400) @(negedge clk);
    #1 refGrant = 1'b0; winFalls = 0;
    repeat (1000) @(negedge clk);
    #1;
    check(winFalls == 0, "R8 no start without grant", winFalls, 0);
    check(refReq == 1, "R9 pending held", int'(refReq), 1);
    refGrant = 1'b1; winFalls = 0;
    repeat (200) @(negedge clk);
    #1;
    check(winFalls >= MAXP && winFalls <= MAXP + 2, "R9 capped drain", winFalls, MAXP);
    for (int k = 0; k < 80; k++) begin
      refGrant = (k % 3) != 0;
      repeat (7) @(negedge clk);
      #1;
    end
    refGrant = 1'b0;
    repeat (50) @(negedge clk);
    finishRun();
  end

endmodule